// File: doc/BRIEF.md
# Shift-Register Clock Divider Set

This block holds the programmable dividers of a clock synthesiser: a 6-bit reference divider, an 8-bit feedback divider, and a pair of cascaded post-dividers. The analogue oscillator and phase comparator are not part of it. The reference and feedback dividers are not binary counters. Each one is a shift register with XNOR feedback that advances on every clock. When its state reaches all-ones, it reloads from a programmable reload register, and its output toggles on that same edge.

Software selects a divide ratio by writing the sequence value that lies the required number of steps before the terminal state. The two post-divide ratios, each from 1 to 8, are written as eight minus the ratio. Each output is a toggle, so each divider output completes one full period every two divide intervals.

Top module: `lfsr_pll_divider`

## Requirements
- R1: While `rst_n` is low, all three outputs are 0. After reset the reload registers hold M=0x3F, N=0xFF and post=0x3F, so every output toggles on every clock.
- R2: A write is sampled on a rising clock edge when `wr_en` is high. `wr_sel` 0 loads the M reload from `wr_data[5:0]`, 1 loads the N reload from `wr_data[7:0]`, and 2 loads the post code from `wr_data[5:0]`. Selector 3 and writes to one selector leave the other registers unchanged.
- R3: The M divider shifts left, and its new bit is the XNOR of bits 5 and 4. State 0x00 steps to the terminal value 0x3F. Its output toggles once per divide interval. Measured intervals are: reload 0x3F gives 1, 0x00 gives 2, 0x20 gives 3, 0x10 gives 4, 0x28 gives 5, 0x25 gives 10, 0x3E gives 59, 0x1F gives 60, 0x03 gives 63 and 0x01 gives 64.
- R4: Across all 64 M reload values, every interval from 1 to 64 occurs exactly once.
- R5: The N divider shifts left, and its new bit is the XNOR of bits 7, 3, 2 and 1. State 0x00 steps to the terminal value 0xFF. Measured intervals are: 0x00 gives 2, 0x80 gives 3, 0xC0 gives 4, 0xE0 gives 5, 0x2F gives 10, 0x85 gives 13, 0xD2 gives 159 and 0x69 gives 160.
- R6: Across all 256 N reload values, every interval from 1 to 256 occurs exactly once.
- R7: The post code holds (8 − pd1) in bits 2:0 and (8 − pd2) in bits 5:3. The post output toggles every pd1·pd2 clocks.
- R8: Writing a post code ORed with 0x09 and then the plain code on the next clock leaves the plain ratio in force.
- R9: A new M or N reload value is used only at the next terminal state. The interval already running finishes at its old length.
- R10: A new post code is adopted only on a post output toggle. The interval already running finishes at its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every divider steps on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Register select: 0 M reload, 1 N reload, 2 post code |
| wr_data | input | 8 | Write data |
| m_clk_o | output | 1 | Reference divider output |
| n_clk_o | output | 1 | Feedback divider output |
| post_clk_o | output | 1 | Post-divider output |

## Verification
A wrong feedback tap or a broken zero-to-terminal bridge changes the length of the sequence. That shows at the ports as a wrong toggle interval or as two reload values that give the same interval. This appears within one divide interval after the new reload value is taken up. Sweeping every reload value and requiring each interval to be distinct catches any tap error. Errors in deferred adoption appear on the first toggle after a write made mid-interval, as an interval that is cut short.

// File: rtl/lfsr_pll_divider.sv
module lfsr_pll_divider #(
  parameter int M_W = 6,
  parameter int N_W = 8,
  parameter int P_W = 3,
  parameter logic [M_W-1:0] M_TAPS = 6'b110000,
  parameter logic [N_W-1:0] N_TAPS = 8'b10001110
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_sel,
  input  logic [N_W-1:0] wr_data,
  output logic           m_clk_o,
  output logic           n_clk_o,
  output logic           post_clk_o
);
  localparam logic [1:0] SEL_M = 2'd0;
  localparam logic [1:0] SEL_N = 2'd1;
  localparam logic [1:0] SEL_P = 2'd2;
  localparam int PC_W = 2 * P_W;

  function automatic logic [M_W-1:0] m_step(input logic [M_W-1:0] s);
    if (s == '0) return '1;
    return {s[M_W-2:0], ~^(s & M_TAPS)};
  endfunction

  function automatic logic [N_W-1:0] n_step(input logic [N_W-1:0] s);
    if (s == '0) return '1;
    return {s[N_W-2:0], ~^(s & N_TAPS)};
  endfunction

  logic [M_W-1:0]  m_q, m_rl;
  logic [N_W-1:0]  n_q, n_rl;
  logic [PC_W-1:0] p_code, p_act;
  logic [P_W-1:0]  c1_q, c2_q;
  logic            p_wrap1, p_wrap;

  assign p_wrap1 = (c1_q == ~p_act[P_W-1:0]);
  assign p_wrap  = p_wrap1 && (c2_q == ~p_act[PC_W-1:P_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q     <= '1;
      m_rl    <= '1;
      m_clk_o <= 1'b0;
    end else begin
      if (wr_en && wr_sel == SEL_M) m_rl <= wr_data[M_W-1:0];
      if (&m_q) begin
        m_q     <= m_rl;
        m_clk_o <= ~m_clk_o;
      end else begin
        m_q <= m_step(m_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q     <= '1;
      n_rl    <= '1;
      n_clk_o <= 1'b0;
    end else begin
      if (wr_en && wr_sel == SEL_N) n_rl <= wr_data;
      if (&n_q) begin
        n_q     <= n_rl;
        n_clk_o <= ~n_clk_o;
      end else begin
        n_q <= n_step(n_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_code     <= '1;
      p_act      <= '1;
      c1_q       <= '0;
      c2_q       <= '0;
      post_clk_o <= 1'b0;
    end else begin
      if (wr_en && wr_sel == SEL_P) p_code <= wr_data[PC_W-1:0];
      if (p_wrap1) begin
        c1_q <= '0;
        if (p_wrap) begin
          c2_q       <= '0;
          post_clk_o <= ~post_clk_o;
          p_act      <= p_code;
        end else begin
          c2_q <= c2_q + 1'b1;
        end
      end else begin
        c1_q <= c1_q + 1'b1;
      end
    end
  end
endmodule

module lfsr_pll_divider_chk #(
  parameter int M_W = 6,
  parameter int N_W = 8,
  parameter int P_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [M_W-1:0]   m_state,
  input logic [M_W-1:0]   m_rl,
  input logic             m_out,
  input logic [N_W-1:0]   n_state,
  input logic [N_W-1:0]   n_rl,
  input logic             n_out,
  input logic [2*P_W-1:0] p_act,
  input logic             p_wrap,
  input logic             p_out
);
  // R3
  m_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&m_state) |=> (m_out != $past(m_out)));
  // R3
  m_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&m_state) |=> $stable(m_out));
  // R9
  m_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&m_state) |=> (m_state == $past(m_rl)));
  // R5
  n_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&n_state) |=> (n_out != $past(n_out)));
  // R9
  n_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&n_state) |=> (n_state == $past(n_rl)));
  // R7
  p_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !p_wrap |=> $stable(p_out));
  // R10
  p_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !p_wrap |=> $stable(p_act));
endmodule

bind lfsr_pll_divider lfsr_pll_divider_chk #(.M_W(M_W), .N_W(N_W), .P_W(P_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .m_state(m_q), .m_rl(m_rl), .m_out(m_clk_o),
  .n_state(n_q), .n_rl(n_rl), .n_out(n_clk_o),
  .p_act(p_act), .p_wrap(p_wrap), .p_out(post_clk_o)
);

// File: tb/lfsr_pll_divider_tb_top.sv
module lfsr_pll_divider_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic       m_clk, n_clk, p_clk;
  int         n_vec = 0;
  int         n_bad = 0;

  always #10 clk = ~clk;

  lfsr_pll_divider dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .m_clk_o(m_clk), .n_clk_o(n_clk), .post_clk_o(p_clk)
  );

  // {sel, data, expected interval}
  localparam int NV = 23;
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 8'h3f, 16'd1},  {2'd0, 8'h00, 16'd2},  {2'd0, 8'h20, 16'd3},
    {2'd0, 8'h10, 16'd4},  {2'd0, 8'h28, 16'd5},  {2'd0, 8'h25, 16'd10},
    {2'd0, 8'h3e, 16'd59}, {2'd0, 8'h1f, 16'd60}, {2'd0, 8'h03, 16'd63},
    {2'd0, 8'h01, 16'd64},
    {2'd1, 8'h00, 16'd2},  {2'd1, 8'h80, 16'd3},  {2'd1, 8'hc0, 16'd4},
    {2'd1, 8'he0, 16'd5},  {2'd1, 8'h2f, 16'd10}, {2'd1, 8'h85, 16'd13},
    {2'd1, 8'hd2, 16'd159},{2'd1, 8'h69, 16'd160},
    {2'd2, 8'h35, 16'd6},  {2'd2, 8'h38, 16'd8},  {2'd2, 8'h3f, 16'd1},
    {2'd2, 8'h0b, 16'd35}, {2'd2, 8'h00, 16'd64}
  };

  function automatic logic pick(input int s);
    case (s)
      0:       return m_clk;
      1:       return n_clk;
      default: return p_clk;
    endcase
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input int s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(s); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wt(input int s, output int cyc);
    logic start;
    start = pick(s);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (pick(s) == start);
  endtask

  task automatic measure(input int s, output int d);
    int x;
    wt(s, x);
    wt(s, x);
    wt(s, d);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int d, t;
    bit seen [1:256];
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 m out in reset", int'(m_clk), 0);
    check("R1 n out in reset", int'(n_clk), 0);
    check("R1 post out in reset", int'(p_clk), 0);
    rst_n = 1'b1;
    measure(0, d); check("R1 m reset interval", d, 1);
    measure(1, d); check("R1 n reset interval", d, 1);
    measure(2, d); check("R1 post reset interval", d, 1);

    for (int i = 0; i < NV; i++) begin
      int s;
      s = int'(VEC[i][25:24]);
      wr(s, VEC[i][23:16]);
      measure(s, d);
      check(s == 0 ? "R3 M interval" : s == 1 ? "R5 N interval" : "R7 post interval",
            d, int'(VEC[i][15:0]));
    end

    // R2: writes to N, post and selector 3 leave M at its last value (0x01, 64)
    wr(3, 8'h00);
    measure(0, d); check("R2 M untouched by other selectors", d, 64);

    // R8: workaround sequence
    @(negedge clk); wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h28 | 8'h09;
    @(negedge clk); wr_data = 8'h28;
    @(negedge clk); wr_en = 1'b0;
    measure(2, d); check("R8 pd1=8 pd2=3 after workaround", d, 24);
    @(negedge clk); wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h00 | 8'h09;
    @(negedge clk); wr_data = 8'h00;
    @(negedge clk); wr_en = 1'b0;
    measure(2, d); check("R8 pd1=8 pd2=8 after workaround", d, 64);

    // R10: post change mid interval (currently 64)
    repeat (9) @(negedge clk);
    wr(2, 8'h3f);
    wt(2, t); check("R10 running post interval kept", t + 11, 64);
    wt(2, d); check("R10 new post interval", d, 1);

    // R9: M change mid interval (currently 64)
    measure(0, d);
    repeat (9) @(negedge clk);
    wr(0, 8'h3f);
    wt(0, t); check("R9 running M interval kept", t + 11, 64);
    wt(0, d); check("R9 new M interval", d, 1);

    // R9: N change mid interval (currently 160)
    measure(1, d);
    repeat (9) @(negedge clk);
    wr(1, 8'h00);
    wt(1, t); check("R9 running N interval kept", t + 11, 160);
    wt(1, d); check("R9 new N interval", d, 2);

    // R4: every M reload value gives a distinct interval 1..64
    for (int i = 1; i <= 256; i++) seen[i] = 1'b0;
    for (int v = 0; v < 64; v++) begin
      wr(0, 8'(v));
      measure(0, d);
      n_vec++;
      if (d < 1 || d > 64 || seen[d]) begin
        n_bad++;
        $display("FAIL R4 reload %02h: got %0d expected unused interval in 1..64", v, d);
      end else seen[d] = 1'b1;
    end

    // R6: every N reload value gives a distinct interval 1..256
    for (int i = 1; i <= 256; i++) seen[i] = 1'b0;
    for (int v = 0; v < 256; v++) begin
      wr(1, 8'(v));
      measure(1, d);
      n_vec++;
      if (d < 1 || d > 256 || seen[d]) begin
        n_bad++;
        $display("FAIL R6 reload %02h: got %0d expected unused interval in 1..256", v, d);
      end else seen[d] = 1'b1;
    end

    summary();
    $finish;
  end
endmodule